// File: doc/BRIEF.md
# Epoch-Based Fetch and Decode Redirect Controller

This block decides, cycle by cycle, where fetch goes next in a pipeline where two later stages can correct the front end. The execute stage knows the real outcome of a control instruction. The decode stage makes an earlier guess by comparing the fetch-time prediction with a direction-predicted next pc. Every fetched instruction carries two single-bit epoch tags. Decode uses these tags to tell whether the instruction is still on the right path. It does not need to search or flush the pipeline to find out.

Fetch keeps its own copy of the execute epoch and of the decode epoch. Decode keeps its own copy of the execute epoch and owns the decode epoch. A mispredicting execute message always steers fetch. A redirect raised by decode is parked in a one-entry holding register and is applied on the next cycle. It is applied only when no execute redirect is present and the message's execute epoch still matches fetch's copy. Otherwise it is thrown away. Every execute message is also forwarded to the predictor training outputs, whether or not it mispredicted. The predictors and the execute datapath lie outside this block.

Top module: `epoch_redirect_ctrl`

## Requirements
- R1: After reset, fetch_pc_o equals RESET_PC, both tag outputs are 0, and the decode-side epochs are 0, so an instruction tagged (0,0) is classified as normal.
- R2: With no redirect present and no decode message pending, fetch_fire_o is 1 and the tag outputs show the current fetch epochs. On the next edge fetch_pc_o takes btb_pc_i.
- R3: When ex_valid_i and ex_mispred_i are both 1, fetch_pc_o takes ex_target_i and tag_eep_o toggles on the next edge, and fetch_fire_o is 0 in that cycle.
- R4: Every cycle with ex_valid_i = 1 drives train_valid_o = 1, with train_pc_o, train_target_o and train_taken_o copying the execute message, in the same cycle and whether or not the message mispredicts. A message that does not mispredict leaves the epochs alone and lets fetch advance as in R2.
- R5: A decode redirect raised in cycle t is applied in cycle t+1 when no execute redirect is present and its execute epoch equals tag_eep_o. Then fetch_fire_o is 0, and on that edge fetch_pc_o takes the message target and tag_dep_o takes the message's decode epoch.
- R6: An execute redirect overrules a pending decode message in the same cycle, and the pending message is kept for the following cycle.
- R7: A pending decode message whose execute epoch differs from tag_eep_o is discarded. In that cycle fetch_fire_o is 0, and fetch_pc_o and tag_dep_o stay unchanged.
- R8: A valid decode input whose execute epoch differs from decode's execute epoch is classified as resync (dec_kind_o = 2). Decode adopts both of its epochs from the instruction and processes it normally.
- R9: If the execute epochs match, an instruction whose decode epoch equals decode's own is normal (dec_kind_o = 1). Otherwise it is dropped (dec_kind_o = 3, dec_drop_o = 1). A dropped instruction raises no redirect and changes no epoch. dec_kind_o = 0 when dec_valid_i = 0.
- R10: A normal or resync instruction whose predicted pc differs from its ppc raises dec_redir_valid_o in the same cycle. The message carries the instruction pc, the predicted pc as target, the instruction's execute epoch, and the toggled decode epoch (dec_redir_dep_o), which decode also adopts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btb_pc_i | input | ADDR_W | Next-address prediction for the current fetch pc |
| fetch_pc_o | output | ADDR_W | Current fetch pc |
| fetch_fire_o | output | 1 | Instruction at fetch_pc_o is sent to decode this cycle |
| tag_eep_o | output | 1 | Execute-epoch tag for the fetched instruction |
| tag_dep_o | output | 1 | Decode-epoch tag for the fetched instruction |
| ex_valid_i | input | 1 | Execute message for a control instruction |
| ex_mispred_i | input | 1 | Execute message reports a misprediction |
| ex_taken_i | input | 1 | Resolved direction |
| ex_pc_i | input | ADDR_W | pc of the resolved instruction |
| ex_target_i | input | ADDR_W | Correct next pc |
| train_valid_o | output | 1 | Training message valid |
| train_taken_o | output | 1 | Training direction |
| train_pc_o | output | ADDR_W | Training pc |
| train_target_o | output | ADDR_W | Training next pc |
| dec_valid_i | input | 1 | Instruction present at decode |
| dec_pc_i | input | ADDR_W | Its pc |
| dec_ppc_i | input | ADDR_W | Its fetch-time predicted next pc |
| dec_pred_pc_i | input | ADDR_W | Direction-predicted next pc at decode |
| dec_eep_i | input | 1 | Its execute-epoch tag |
| dec_dep_i | input | 1 | Its decode-epoch tag |
| dec_kind_o | output | 2 | 0 idle, 1 normal, 2 resync, 3 drop |
| dec_drop_o | output | 1 | Instruction is wrong-path |
| dec_redir_valid_o | output | 1 | Decode raises a redirect |
| dec_redir_pc_o | output | ADDR_W | pc of the redirecting instruction |
| dec_redir_target_o | output | ADDR_W | Redirect target |
| dec_redir_eep_o | output | 1 | Execute epoch carried by the message |
| dec_redir_dep_o | output | 1 | New decode epoch carried by the message |

## Verification
Decode classification, the redirect message and the training outputs are combinational, so they are due in the cycle of the stimulus. Fetch pc and tags change on the edge that ends the cycle of an execute redirect or normal advance. A decode redirect reaches the fetch pc one edge later, after it passes through the holding register. The bench drives inputs on the falling edge and checks same-cycle results shortly after. It checks registered results on the falling edge after the rising edge that loads them. In the two-edge cases it checks fetch_fire_o in the middle cycle.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic [1:0] {
    DK_IDLE   = 2'd0,
    DK_OK     = 2'd1,
    DK_RESYNC = 2'd2,
    DK_DROP   = 2'd3
  } dec_kind_e;
endpackage

// File: rtl/erc_decode_unit.sv
module erc_decode_unit
  import erc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] ppc_i,
  input  logic [ADDR_W-1:0] pred_pc_i,
  input  logic              eep_i,
  input  logic              dep_i,
  output dec_kind_e         kind_o,
  output logic              drop_o,
  output logic              redir_o,
  output logic [ADDR_W-1:0] redir_pc_o,
  output logic [ADDR_W-1:0] redir_tgt_o,
  output logic              redir_eep_o,
  output logic              redir_dep_o
);
  logic de_q, d_q;
  logic de_d, d_d;
  logic eff_dep;
  logic accept;

  always_comb begin
    kind_o  = DK_IDLE;
    eff_dep = d_q;
    if (valid_i) begin
      if (eep_i != de_q) begin
        kind_o  = DK_RESYNC;
        eff_dep = dep_i;
      end else if (dep_i == d_q) begin
        kind_o = DK_OK;
      end else begin
        kind_o = DK_DROP;
      end
    end
  end

  assign accept      = (kind_o == DK_OK) || (kind_o == DK_RESYNC);
  assign drop_o      = (kind_o == DK_DROP);
  assign redir_o     = accept && (pred_pc_i != ppc_i);
  assign redir_pc_o  = pc_i;
  assign redir_tgt_o = pred_pc_i;
  assign redir_eep_o = eep_i;
  assign redir_dep_o = ~eff_dep;

  always_comb begin
    de_d = de_q;
    d_d  = d_q;
    if (accept) begin
      de_d = eep_i;
      d_d  = redir_o ? ~eff_dep : eff_dep;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q <= 1'b0;
      d_q  <= 1'b0;
    end else begin
      de_q <= de_d;
      d_q  <= d_d;
    end
  end

  assert_drop_no_redir_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !redir_o);
  assert_drop_keeps_epochs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> ($stable(d_q) && $stable(de_q)));
  assert_resync_adopts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == DK_RESYNC) |=> (de_q == $past(eep_i)));
  assert_redir_toggles_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |=> (d_q == $past(redir_dep_o)));
endmodule

// File: rtl/erc_redirect_hold.sv
module erc_redirect_hold #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic              eep_i,
  input  logic              dep_i,
  input  logic              consume_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              eep_o,
  output logic              dep_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] tgt_q;
  logic              eep_q, dep_q;

  // a newer decode message supersedes a pending one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tgt_q   <= '0;
      eep_q   <= 1'b0;
      dep_q   <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      tgt_q   <= tgt_i;
      eep_q   <= eep_i;
      dep_q   <= dep_i;
    end else if (consume_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign tgt_o   = tgt_q;
  assign eep_o   = eep_q;
  assign dep_o   = dep_q;

  assert_hold_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !consume_i && !load_i) |=> (valid_q && $stable(tgt_q)));
endmodule

// File: rtl/erc_fetch_unit.sv
module erc_fetch_unit #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ex_redir_i,
  input  logic [ADDR_W-1:0] ex_tgt_i,
  input  logic              hold_v_i,
  input  logic [ADDR_W-1:0] hold_tgt_i,
  input  logic              hold_eep_i,
  input  logic              hold_dep_i,
  input  logic [ADDR_W-1:0] btb_pc_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              fe_o,
  output logic              fd_o,
  output logic              fire_o,
  output logic              consume_o
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              fe_q, fe_d, fd_q, fd_d;

  assign consume_o = hold_v_i && !ex_redir_i;
  assign fire_o    = !ex_redir_i && !hold_v_i;

  always_comb begin
    pc_d = pc_q;
    fe_d = fe_q;
    fd_d = fd_q;
    if (ex_redir_i) begin
      pc_d = ex_tgt_i;
      fe_d = ~fe_q;
    end else if (hold_v_i) begin
      if (hold_eep_i == fe_q) begin
        pc_d = hold_tgt_i;
        fd_d = hold_dep_i;
      end
    end else begin
      pc_d = btb_pc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= RESET_PC;
      fe_q <= 1'b0;
      fd_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      fe_q <= fe_d;
      fd_q <= fd_d;
    end
  end

  assign pc_o = pc_q;
  assign fe_o = fe_q;
  assign fd_o = fd_q;

  assert_ex_redirect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_redir_i |=> ((fe_q != $past(fe_q)) && (pc_q == $past(ex_tgt_i))));
  assert_ex_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_redir_i |-> (!fire_o && !consume_o));
  assert_stale_discard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_v_i && !ex_redir_i && (hold_eep_i != fe_q)) |=> ($stable(pc_q) && $stable(fd_q)));
  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> ((pc_q == $past(btb_pc_i)) && $stable(fe_q) && $stable(fd_q)));
endmodule

// File: rtl/epoch_redirect_ctrl.sv
module epoch_redirect_ctrl
  import erc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] btb_pc_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic              fetch_fire_o,
  output logic              tag_eep_o,
  output logic              tag_dep_o,
  input  logic              ex_valid_i,
  input  logic              ex_mispred_i,
  input  logic              ex_taken_i,
  input  logic [ADDR_W-1:0] ex_pc_i,
  input  logic [ADDR_W-1:0] ex_target_i,
  output logic              train_valid_o,
  output logic              train_taken_o,
  output logic [ADDR_W-1:0] train_pc_o,
  output logic [ADDR_W-1:0] train_target_o,
  input  logic              dec_valid_i,
  input  logic [ADDR_W-1:0] dec_pc_i,
  input  logic [ADDR_W-1:0] dec_ppc_i,
  input  logic [ADDR_W-1:0] dec_pred_pc_i,
  input  logic              dec_eep_i,
  input  logic              dec_dep_i,
  output logic [1:0]        dec_kind_o,
  output logic              dec_drop_o,
  output logic              dec_redir_valid_o,
  output logic [ADDR_W-1:0] dec_redir_pc_o,
  output logic [ADDR_W-1:0] dec_redir_target_o,
  output logic              dec_redir_eep_o,
  output logic              dec_redir_dep_o
);
  logic              ex_redir;
  logic              hold_v, hold_eep, hold_dep, consume;
  logic [ADDR_W-1:0] hold_tgt;
  dec_kind_e         kind;

  assign ex_redir = ex_valid_i && ex_mispred_i;

  // training path: every execute message, mispredicted or not
  assign train_valid_o  = ex_valid_i;
  assign train_taken_o  = ex_taken_i;
  assign train_pc_o     = ex_pc_i;
  assign train_target_o = ex_target_i;

  erc_decode_unit #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (dec_valid_i),
    .pc_i        (dec_pc_i),
    .ppc_i       (dec_ppc_i),
    .pred_pc_i   (dec_pred_pc_i),
    .eep_i       (dec_eep_i),
    .dep_i       (dec_dep_i),
    .kind_o      (kind),
    .drop_o      (dec_drop_o),
    .redir_o     (dec_redir_valid_o),
    .redir_pc_o  (dec_redir_pc_o),
    .redir_tgt_o (dec_redir_target_o),
    .redir_eep_o (dec_redir_eep_o),
    .redir_dep_o (dec_redir_dep_o)
  );

  assign dec_kind_o = kind;

  erc_redirect_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (dec_redir_valid_o),
    .tgt_i     (dec_redir_target_o),
    .eep_i     (dec_redir_eep_o),
    .dep_i     (dec_redir_dep_o),
    .consume_i (consume),
    .valid_o   (hold_v),
    .tgt_o     (hold_tgt),
    .eep_o     (hold_eep),
    .dep_o     (hold_dep)
  );

  erc_fetch_unit #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ex_redir_i (ex_redir),
    .ex_tgt_i   (ex_target_i),
    .hold_v_i   (hold_v),
    .hold_tgt_i (hold_tgt),
    .hold_eep_i (hold_eep),
    .hold_dep_i (hold_dep),
    .btb_pc_i   (btb_pc_i),
    .pc_o       (fetch_pc_o),
    .fe_o       (tag_eep_o),
    .fd_o       (tag_dep_o),
    .fire_o     (fetch_fire_o),
    .consume_o  (consume)
  );

  assert_train_every_msg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_valid_i |-> (train_valid_o && (train_target_o == ex_target_i)));
  assert_drop_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dec_drop_o, dec_redir_valid_o}));
endmodule

// File: tb/tb_epoch_redirect_ctrl.sv
`timescale 1ns/1ps
module tb_epoch_redirect_ctrl;
  localparam int AW = 32;
  localparam logic [AW-1:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] btb_pc, fetch_pc, ex_pc, ex_tgt, tr_pc, tr_tgt;
  logic [AW-1:0] d_pc, d_ppc, d_pred, r_pc, r_tgt;
  logic fire, t_e, t_d, ex_v, ex_m, ex_t, tr_v, tr_t;
  logic d_v, d_e, d_d, drop, r_v, r_e, r_d;
  logic [1:0] kind;

  int checks = 0;
  int fails = 0;

  epoch_redirect_ctrl #(.ADDR_W(AW), .RESET_PC(RPC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .btb_pc_i(btb_pc),
    .fetch_pc_o(fetch_pc), .fetch_fire_o(fire), .tag_eep_o(t_e), .tag_dep_o(t_d),
    .ex_valid_i(ex_v), .ex_mispred_i(ex_m), .ex_taken_i(ex_t),
    .ex_pc_i(ex_pc), .ex_target_i(ex_tgt),
    .train_valid_o(tr_v), .train_taken_o(tr_t), .train_pc_o(tr_pc), .train_target_o(tr_tgt),
    .dec_valid_i(d_v), .dec_pc_i(d_pc), .dec_ppc_i(d_ppc), .dec_pred_pc_i(d_pred),
    .dec_eep_i(d_e), .dec_dep_i(d_d), .dec_kind_o(kind), .dec_drop_o(drop),
    .dec_redir_valid_o(r_v), .dec_redir_pc_o(r_pc), .dec_redir_target_o(r_tgt),
    .dec_redir_eep_o(r_e), .dec_redir_dep_o(r_d)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic idle();
    ex_v = 0; ex_m = 0; ex_t = 0; ex_pc = '0; ex_tgt = '0;
    d_v = 0; d_pc = '0; d_ppc = '0; d_pred = '0; d_e = 0; d_d = 0;
  endtask

  // from a falling edge, through one rising edge, to the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  task automatic dec_in(input logic e, input logic d, input logic [AW-1:0] pc,
                        input logic [AW-1:0] ppc, input logic [AW-1:0] pred);
    d_v = 1; d_e = e; d_d = d; d_pc = pc; d_ppc = ppc; d_pred = pred;
  endtask

  task automatic t_reset();
    #0.5;
    chk_eq("R1 pc", fetch_pc, RPC);
    chk_eq("R1 tag_eep", t_e, 0);
    chk_eq("R1 tag_dep", t_d, 0);
    dec_in(0, 0, 32'h100, 32'h104, 32'h104);
    #0.5;
    chk_eq("R1 decode epochs zero -> normal", kind, 1);
    idle();
  endtask

  task automatic t_advance();
    btb_pc = 32'h1004;
    #0.5;
    chk_eq("R2 fire", fire, 1);
    step();
    chk_eq("R2 pc from btb", fetch_pc, 32'h1004);
    chk_eq("R2 tags kept", {t_e, t_d}, 2'b00);
  endtask

  task automatic t_ex_redirect();
    ex_v = 1; ex_m = 1; ex_t = 1; ex_pc = 32'h1000; ex_tgt = 32'h2000;
    #0.5;
    chk_eq("R3 fire low", fire, 0);
    chk_eq("R4 train on mispredict", {tr_v, tr_t}, 2'b11);
    step();
    idle();
    chk_eq("R3 pc", fetch_pc, 32'h2000);
    chk_eq("R3 eep toggled", t_e, 1);
    chk_eq("R3 dep kept", t_d, 0);
  endtask

  task automatic t_train_only();
    ex_v = 1; ex_m = 0; ex_t = 0; ex_pc = 32'h2abc; ex_tgt = 32'h3000;
    btb_pc = 32'h2004;
    #0.5;
    chk_eq("R4 train valid", tr_v, 1);
    chk_eq("R4 train pc", tr_pc, 32'h2abc);
    chk_eq("R4 train target", tr_tgt, 32'h3000);
    chk_eq("R4 fire on correct prediction", fire, 1);
    step();
    idle();
    chk_eq("R4 pc advances normally", fetch_pc, 32'h2004);
    chk_eq("R4 eep unchanged", t_e, 1);
  endtask

  task automatic t_decode_normal();
    dec_in(0, 0, 32'h400, 32'h404, 32'h404);
    #0.5;
    chk_eq("R9 normal kind", kind, 1);
    chk_eq("R10 no redirect when match", r_v, 0);
    step();
    idle();
  endtask

  task automatic t_resync_apply();
    // decode epochs (0,0); fetch eep=1, dep=0
    dec_in(1, 0, 32'h500, 32'h504, 32'h5000);
    #0.5;
    chk_eq("R8 resync kind", kind, 2);
    chk_eq("R10 redir valid", r_v, 1);
    chk_eq("R10 redir pc", r_pc, 32'h500);
    chk_eq("R10 redir target", r_tgt, 32'h5000);
    chk_eq("R10 redir eep", r_e, 1);
    chk_eq("R10 redir dep toggled", r_d, 1);
    btb_pc = 32'h2008;
    step();
    idle();
    chk_eq("R2 advance while decode raises", fetch_pc, 32'h2008);
    chk_eq("R5 fire low while applying", fire, 0);
    step();
    chk_eq("R5 pc from decode", fetch_pc, 32'h5000);
    chk_eq("R5 dep from message", t_d, 1);
    chk_eq("R5 eep kept", t_e, 1);
    chk_eq("R5 fire restored", fire, 1);
  endtask

  task automatic t_drop();
    // decode epochs now (1,1)
    btb_pc = fetch_pc;
    dec_in(1, 0, 32'h600, 32'h604, 32'h9999);
    #0.5;
    chk_eq("R9 drop kind", kind, 3);
    chk_eq("R9 drop flag", drop, 1);
    chk_eq("R9 no redirect on drop", r_v, 0);
    step();
    dec_in(1, 1, 32'h608, 32'h60c, 32'h60c);
    #0.5;
    chk_eq("R9 epochs unchanged after drop", kind, 1);
    step();
    idle();
    chk_eq("R9 fetch untouched by drop", fire, 1);
  endtask

  task automatic t_ex_beats_decode_same_cycle();
    // fetch (1,1), decode (1,1)
    ex_v = 1; ex_m = 1; ex_tgt = 32'h6000;
    dec_in(1, 1, 32'h700, 32'h704, 32'h7000);
    #0.5;
    chk_eq("R10 redir raised", r_v, 1);
    chk_eq("R6 fire low", fire, 0);
    step();
    idle();
    chk_eq("R6 execute wins", fetch_pc, 32'h6000);
    chk_eq("R3 eep toggled to 0", t_e, 0);
    chk_eq("R7 fire low during discard", fire, 0);
    step();
    chk_eq("R7 pc held on discard", fetch_pc, 32'h6000);
    chk_eq("R7 dep unchanged", t_d, 1);
    chk_eq("R7 queue empty after discard", fire, 1);
  endtask

  task automatic t_pending_kept();
    // fetch (0,1); decode de=1, d=0
    btb_pc = fetch_pc;
    dec_in(0, 1, 32'h800, 32'h804, 32'h8000);
    #0.5;
    chk_eq("R8 resync again", kind, 2);
    chk_eq("R10 dep toggled from adopted", r_d, 0);
    step();
    idle();
    ex_v = 1; ex_m = 1; ex_tgt = 32'h9000;
    #0.5;
    chk_eq("R6 fire low with both", fire, 0);
    step();
    idle();
    chk_eq("R6 execute target taken", fetch_pc, 32'h9000);
    chk_eq("R6 pending kept", fire, 0);
    step();
    chk_eq("R7 stale pending discarded, pc held", fetch_pc, 32'h9000);
    chk_eq("R7 dep unchanged", t_d, 1);
    chk_eq("R7 eep", t_e, 1);
  endtask

  initial begin
    idle();
    btb_pc = '0;
    fork
      begin
        #20;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_advance();
        t_ex_redirect();
        t_train_only();
        t_decode_normal();
        t_resync_apply();
        t_drop();
        t_ex_beats_decode_same_cycle();
        t_pending_kept();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
      end
    join_any
    disable fork;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule